// File: doc/BRIEF.md
# Three-Bank Interrupt Priority Resolver

This block turns three 8-bit request vectors into one interrupt number and a valid flag. The vectors have already been masked, and the block looks at nothing else. The three banks are called upper, transfer and base. They are looked at in a fixed order, and the first bank with any bit set supplies the winner. Inside each bank the bits are not ranked from lowest to highest. Each bank has its own fixed order that mixes the bit positions up, and each bank has its own range of numbers.

The upper bank gives numbers 8 to 15, the transfer bank gives 16 to 23 and the base bank gives 0 to 7. The base bank's bit 0 produces number 0, so number 0 on its own cannot mean that nothing is pending. The valid flag carries that information instead. Software or a sequencer reads the result as the next interrupt to service.

A parameter selects one of two timings. The result is either combinational, or it passes through one output register that a synchronous reset clears.

Top module: `irq_bank_resolver`

## Requirements
- R1: The upper bank takes precedence over the transfer bank, and the transfer bank takes precedence over the base bank. A bank with any bit set hides every bank ranked below it.
- R2: Upper bank bit n gives number 8+n. Among its set bits the winner is taken in this order, from highest rank to lowest: bit 2, 3, 5, 7, 6, 0, 1, 4.
- R3: Transfer bank bit n gives number 16+n. Its ranking, from highest to lowest, is bit 0, 1, 2, 3, 5, 6, 7, 4.
- R4: Base bank bit n gives number n. Its ranking, from highest to lowest, is bit 7, 5, 3, 6, 2, 0, 1, 4.
- R5: When all three vectors are zero, `irq_valid` is 0.
- R6: While `irq_valid` is 0, `irq_num` is 0.
- R7: A request on base bit 0 alone gives `irq_valid`=1 and `irq_num`=0.
- R8: With REGISTERED=1, the outputs show the result for the inputs sampled at the previous rising clock edge. A synchronous `rst` clears both outputs to 0.
- R9: With REGISTERED=0, the outputs follow the inputs within the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| upper_req | input | 8 | Masked requests of the upper bank |
| xfer_req | input | 8 | Masked requests of the transfer bank |
| base_req | input | 8 | Masked requests of the base bank |
| irq_valid | output | 1 | High when any request is pending |
| irq_num | output | 5 | Number of the winning request, 0 when none |

## Verification
The bench drives all 256 patterns of each bank while the other two banks are zero. A design that ranked bits from the lowest position would fail on many patterns, for example upper 0x21, where bit 5 must win. Mixed patterns across two and three banks would expose a wrong bank order, or a lower bank leaking into a higher one. The lone base bit 0 case would catch a design that reports number 0 as "none". A reset asserted while requests are present would show a register that ignores reset or that takes a cycle too many to clear.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int BANK_W = 8;
  localparam int IDX_W  = $clog2(BANK_W);
  localparam int NUM_W  = 5;

  // Slot k holds the bit index with rank k; slot 0 is the strongest.
  localparam logic [BANK_W*IDX_W-1:0] UPPER_ORDER =
    {3'd4, 3'd1, 3'd0, 3'd6, 3'd7, 3'd5, 3'd3, 3'd2};
  localparam logic [BANK_W*IDX_W-1:0] XFER_ORDER =
    {3'd4, 3'd7, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [BANK_W*IDX_W-1:0] BASE_ORDER =
    {3'd4, 3'd1, 3'd0, 3'd2, 3'd6, 3'd3, 3'd5, 3'd7};

  localparam int UPPER_BASE = 8;
  localparam int XFER_BASE  = 16;
  localparam int BASE_BASE  = 0;

  typedef struct packed {
    logic             valid;
    logic [NUM_W-1:0] num;
  } pick_t;

endpackage

// File: rtl/bank_pick.sv
module bank_pick
  import irq_prio_pkg::*;
#(
  parameter int W     = BANK_W,
  parameter int IW    = IDX_W,
  parameter int NW    = NUM_W,
  parameter logic [W*IW-1:0] ORDER = UPPER_ORDER,
  parameter int BASE  = 0
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [NW-1:0] num
);

  logic [IW-1:0] sel;

  // Walk from the weakest rank to the strongest; a stronger set bit overwrites.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req[ORDER[k*IW +: IW]]) begin
        hit = 1'b1;
        sel = ORDER[k*IW +: IW];
      end
    end
  end

  assign num = hit ? (NW'(BASE) + NW'(sel)) : '0;

endmodule

// File: rtl/bank_select.sv
module bank_select
  import irq_prio_pkg::*;
(
  input  pick_t upper,
  input  pick_t xfer,
  input  pick_t base,
  output pick_t win
);

  always_comb begin
    if (upper.valid)      win = upper;
    else if (xfer.valid)  win = xfer;
    else if (base.valid)  win = base;
    else                  win = '0;
  end

endmodule

// File: rtl/irq_bank_resolver.sv
module irq_bank_resolver
  import irq_prio_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] upper_req,
  input  logic [BANK_W-1:0] xfer_req,
  input  logic [BANK_W-1:0] base_req,
  output logic              irq_valid,
  output logic [NUM_W-1:0]  irq_num
);

  pick_t up_p, xf_p, bs_p, comb_win;

  bank_pick #(.ORDER(UPPER_ORDER), .BASE(UPPER_BASE)) u_upper (
    .req(upper_req), .hit(up_p.valid), .num(up_p.num));
  bank_pick #(.ORDER(XFER_ORDER), .BASE(XFER_BASE)) u_xfer (
    .req(xfer_req), .hit(xf_p.valid), .num(xf_p.num));
  bank_pick #(.ORDER(BASE_ORDER), .BASE(BASE_BASE)) u_base (
    .req(base_req), .hit(bs_p.valid), .num(bs_p.num));

  bank_select u_sel (
    .upper(up_p), .xfer(xf_p), .base(bs_p), .win(comb_win));

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  generate
    if (REGISTERED) begin : g_reg
      pick_t out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= comb_win;
      end
      assign irq_valid = out_q.valid;
      assign irq_num   = out_q.num;

      p_latency_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (irq_valid == $past(comb_win.valid)) && (irq_num == $past(comb_win.num)));
    end else begin : g_comb
      assign irq_valid = comb_win.valid;
      assign irq_num   = comb_win.num;
    end
  endgenerate

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (irq_num == '0));
  p_none_r5: assert property (@(posedge clk) disable iff (rst)
    (upper_req == '0 && xfer_req == '0 && base_req == '0) |-> !comb_win.valid);
  p_upper_wins_r1: assert property (@(posedge clk) disable iff (rst)
    (upper_req != '0) |-> (comb_win.valid && comb_win.num >= 5'd8 && comb_win.num <= 5'd15));
  p_xfer_range_r3: assert property (@(posedge clk) disable iff (rst)
    (upper_req == '0 && xfer_req != '0) |->
      (comb_win.valid && comb_win.num >= 5'd16 && comb_win.num <= 5'd23));
  p_base_range_r4: assert property (@(posedge clk) disable iff (rst)
    (upper_req == '0 && xfer_req == '0 && base_req != '0) |->
      (comb_win.valid && comb_win.num <= 5'd7));
  p_base_bit0_r7: assert property (@(posedge clk) disable iff (rst)
    (upper_req == '0 && xfer_req == '0 && base_req == 8'h01) |->
      (comb_win.valid && comb_win.num == 5'd0));

endmodule

// File: tb/irq_bank_resolver_test.sv
module irq_bank_resolver_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] up_r = '0, xf_r = '0, bs_r = '0;
  logic       v_reg, v_cmb;
  logic [4:0] n_reg, n_cmb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  irq_bank_resolver #(.REGISTERED(1'b1)) uut (
    .clk(clk), .rst(rst), .upper_req(up_r), .xfer_req(xf_r), .base_req(bs_r),
    .irq_valid(v_reg), .irq_num(n_reg));

  irq_bank_resolver #(.REGISTERED(1'b0)) uut_c (
    .clk(clk), .rst(rst), .upper_req(up_r), .xfer_req(xf_r), .base_req(bs_r),
    .irq_valid(v_cmb), .irq_num(n_cmb));

  logic [5:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [5:0] model(input logic [7:0] h, d, l);
    int oh[8] = '{2, 3, 5, 7, 6, 0, 1, 4};
    int od[8] = '{0, 1, 2, 3, 5, 6, 7, 4};
    int ol[8] = '{7, 5, 3, 6, 2, 0, 1, 4};
    for (int k = 0; k < 8; k++) if (h[oh[k]]) return {1'b1, 5'(8 + oh[k])};
    for (int k = 0; k < 8; k++) if (d[od[k]]) return {1'b1, 5'(16 + od[k])};
    for (int k = 0; k < 8; k++) if (l[ol[k]]) return {1'b1, 5'(ol[k])};
    return 6'd0;
  endfunction

  function automatic string pick_tag(input logic [7:0] h, d, l);
    int nz = int'(h != 0) + int'(d != 0) + int'(l != 0);
    if (nz > 1)  return "R1";
    if (h != 0)  return "R2";
    if (d != 0)  return "R3";
    if (l != 0)  return (l == 8'h01) ? "R7" : "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
               tag, act[5], act[4:0], exp[5], exp[4:0]);
    end
  endtask

  // Driver: apply at negedge, check the combinational instance, queue the registered result.
  task automatic drive(input logic [7:0] h, d, l);
    logic [5:0] e;
    @(negedge clk);
    up_r = h; xf_r = d; bs_r = l;
    e = model(h, d, l);
    exp_q.push_back(e);
    tag_q.push_back(pick_tag(h, d, l));
    #1;
    check({"R9/", pick_tag(h, d, l)}, {v_cmb, n_cmb}, e);
  endtask

  // Monitor: the registered instance shows the result one edge later.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({"R8/", t}, {v_reg, n_reg}, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset", {v_reg, n_reg}, 6'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int p = 0; p < 256; p++) drive(8'(p), 8'h00, 8'h00);   // R2
    for (int p = 0; p < 256; p++) drive(8'h00, 8'(p), 8'h00);   // R3
    for (int p = 0; p < 256; p++) drive(8'h00, 8'h00, 8'(p));   // R4
    drive(8'h00, 8'h00, 8'h01);                                 // R7
    drive(8'h00, 8'h00, 8'h00);                                 // R5
    for (int p = 1; p < 256; p += 17) begin                     // R1 mixes
      drive(8'(p), 8'(255 - p), 8'hFF);
      drive(8'h00, 8'(p), 8'(p ^ 8'h5A));
      drive(8'(p), 8'h00, 8'hFF);
    end
    drive(8'h00, 8'h00, 8'h00);
    @(posedge clk); #3;
    checks++;                                                   // R6
    if (v_reg !== 1'b0 || n_reg !== 5'd0) begin
      errors++;
      $display("FAIL R6: got valid=%0b num=%0d, expected valid=0 num=0", v_reg, n_reg);
    end

    // R8: synchronous reset while requests are held clears the register.
    @(negedge clk);
    up_r = 8'hFF; xf_r = 8'hFF; bs_r = 8'hFF;
    @(posedge clk); #2;
    check("R8 pre-reset", {v_reg, n_reg}, 6'b1_01010);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #2;
    check("R8 sync reset", {v_reg, n_reg}, 6'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    check("R8 after reset", {v_reg, n_reg}, 6'b1_01010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule